// File: doc/BRIEF.md
# SIMD lane extract to scalar

This unit handles the data path of a decoded vector-to-scalar move. It takes a 5-bit element selector, a result-width bit, a destination register number and a 128-bit vector value. From these it finds the element size and the lane index, and it checks that the combination is a legal encoding. It then zero-extends the chosen lane to a 32-bit or 64-bit result and issues a write-back request for the destination register.

The element size comes from the lowest set bit in the low four selector bits. The lane index is formed by the selector bits above that bit. The unit also raises a flag when the encoding is illegal, and another flag when the move should be shown as the plain scalar-move form. All outputs are registered and appear one clock after the input strobe, together with an output valid. A 32-bit result always comes out on the 64-bit data bus with its upper half cleared, so the write-back stage handles both widths in the same way.

Top module: `vlane_extract`

## Requirements
- R1: When selector bits [3:0] are all zero, the encoding is reserved: `out_undef` is 1 and `out_wr_en` is 0.
- R2: The element size follows the lowest set bit in selector bits [3:0]. Bit 0 gives an 8-bit element, bit 1 a 16-bit element, bit 2 a 32-bit element and bit 3 a 64-bit element.
- R3: `in_q`=0 asks for a 32-bit result and `in_q`=1 asks for a 64-bit result. With `in_q`=1, any element narrower than 64 bits is undefined. With `in_q`=0, a 64-bit element is undefined.
- R4: The lane index is formed by the selector bits above the lowest set bit: [4:1] for bytes, [4:2] for halfwords, [4:3] for words and [4] for doublewords. Lane i occupies vector bits [i*esize +: esize], with lane 0 at the least significant end.
- R5: With selector bit 4 at 0, only the low 64 bits of the vector can be selected: bytes 0-7, halfwords 0-3, words 0-1, doubleword 0. With bit 4 at 1, lanes in the upper 64 bits are selected.
- R6: The selected lane is zero-extended. For a 32-bit result, bits [63:32] of `out_data` are zero.
- R7: On an undefined encoding, `out_wr_en` is 0 and `out_data` is zero.
- R8: `out_alias` is 1 exactly when the encoding is legal and the selector matches xx100 (word lane, 32-bit result) or x1000 (doubleword lane, 64-bit result).
- R9: All outputs appear one clock edge after `in_valid`, and `out_rd` carries `in_rd`. In a cycle where `out_valid` is 0, `out_wr_en`, `out_undef` and `out_alias` are 0 and `out_data` is zero.
- R10: While reset is held, every output is zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Strobe for a decoded move |
| in_sel | input | 5 | Element selector field |
| in_q | input | 1 | Result width: 0 for 32 bits, 1 for 64 bits |
| in_rd | input | 5 | Destination register number |
| in_vec | input | 128 | Source vector value |
| out_valid | output | 1 | Result valid, one clock after `in_valid` |
| out_wr_en | output | 1 | Write-back request for a legal move |
| out_rd | output | 5 | Destination register number |
| out_data | output | 64 | Zero-extended lane value |
| out_undef | output | 1 | Illegal or reserved encoding |
| out_alias | output | 1 | Plain-move form applies |

## Verification
The bench sweeps every lane of every element size, in both selector bit-4 halves, against a vector whose bytes each have their top bit set and hold distinct values. This pattern exposes a wrong lane offset, a slice taken from the wrong window half, and a missing zero-extension. All 32 selector values are driven with both width settings against a model derived from the requirements. This separates reserved codes, the two illegal width combinations and the alias cases from ordinary legal moves. Back-to-back and idle cycles, plus an all-ones vector, confirm that results do not leak from one strobe into the next and that narrow results keep their upper half clear.

// File: rtl/vlx_pkg.sv
package vlx_pkg;

   localparam int unsigned NUM_SZ = 4;

   typedef enum logic [1:0] {
      ESZ_BYTE = 2'd0,
      ESZ_HALF = 2'd1,
      ESZ_WORD = 2'd2,
      ESZ_DBL  = 2'd3
   } vlx_esz_e;

   typedef struct packed {
      vlx_esz_e esz;
      logic     undef;
      logic     alias_ok;
   } vlx_dec_t;

   function automatic int unsigned esz_bits(input vlx_esz_e e);
      return 32'd8 << e;
   endfunction

endpackage

// File: rtl/vlx_decode.sv
module vlx_decode
   import vlx_pkg::*;
#(
   parameter int unsigned SEL_W = 5
) (
   input  logic [SEL_W-1:0] sel_i,
   input  logic             wide_i,
   output vlx_dec_t         dec_o
);

   localparam int unsigned SZ_W = $clog2(NUM_SZ);

   if (SEL_W != NUM_SZ + 1) begin : g_bad_sel
      $error("vlx_decode: SEL_W must be one more than the number of sizes");
   end

   logic            found;
   logic [SZ_W-1:0] sz;

   // lowest set bit among the size bits picks the element size
   always_comb begin
      found = 1'b0;
      sz    = '0;
      for (int i = 0; i < int'(NUM_SZ); i++) begin
         if (!found && sel_i[i]) begin
            found = 1'b1;
            sz    = SZ_W'(i);
         end
      end
   end

   logic is_dbl;
   logic bad_width;
   logic illegal;

   assign is_dbl    = (vlx_esz_e'(sz) == ESZ_DBL);
   assign bad_width = wide_i ? !is_dbl : is_dbl;
   assign illegal   = !found || bad_width;

   always_comb begin
      dec_o.esz      = vlx_esz_e'(sz);
      dec_o.undef    = illegal;
      // xx100 and x1000 are exactly the word and doubleword sizes
      dec_o.alias_ok = !illegal &&
                       ((vlx_esz_e'(sz) == ESZ_WORD) || is_dbl);
   end

endmodule

// File: rtl/vlx_lane_mux.sv
module vlx_lane_mux
   import vlx_pkg::*;
#(
   parameter int unsigned VEC_W = 128,
   parameter int unsigned SEL_W = 5,
   parameter int unsigned OUT_W = 64
) (
   input  logic [VEC_W-1:0] vec_i,
   input  logic [SEL_W-1:0] sel_i,
   input  vlx_esz_e         esz_i,
   input  logic             wide_i,
   output logic [OUT_W-1:0] data_o
);

   localparam int unsigned NARROW_W = OUT_W / 2;
   localparam int unsigned MAX_EW   = 8 << (NUM_SZ - 1);

   if (MAX_EW != OUT_W) begin : g_bad_out
      $error("vlx_lane_mux: OUT_W must equal the widest element");
   end
   if (VEC_W != (MAX_EW << 1)) begin : g_bad_vec
      $error("vlx_lane_mux: VEC_W must hold two of the widest element");
   end

   logic [OUT_W-1:0] lane_ext [NUM_SZ];

   // one extractor per element size; index bits sit above the size bit
   for (genvar s = 0; s < int'(NUM_SZ); s++) begin : g_size
      localparam int unsigned EW = 8 << s;
      localparam int unsigned IW = SEL_W - 1 - s;
      logic [IW-1:0] idx;
      logic [EW-1:0] lane;
      assign idx         = sel_i[SEL_W-1:s+1];
      assign lane        = vec_i[int'(idx) * EW +: EW];
      assign lane_ext[s] = OUT_W'(lane);
   end

   logic [OUT_W-1:0] picked;
   assign picked = lane_ext[esz_i];
   assign data_o = wide_i ? picked : OUT_W'(picked[NARROW_W-1:0]);

endmodule

// File: rtl/vlane_extract.sv
module vlane_extract
   import vlx_pkg::*;
#(
   parameter int unsigned VEC_W = 128,
   parameter int unsigned SEL_W = 5,
   parameter int unsigned RD_W  = 5,
   parameter int unsigned OUT_W = 64
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             in_valid,
   input  logic [SEL_W-1:0] in_sel,
   input  logic             in_q,
   input  logic [RD_W-1:0]  in_rd,
   input  logic [VEC_W-1:0] in_vec,
   output logic             out_valid,
   output logic             out_wr_en,
   output logic [RD_W-1:0]  out_rd,
   output logic [OUT_W-1:0] out_data,
   output logic             out_undef,
   output logic             out_alias
);

   localparam int unsigned NARROW_W = OUT_W / 2;

   if (RD_W < 1) begin : g_bad_rd
      $error("vlane_extract: RD_W must be at least 1");
   end

   vlx_dec_t         dec;
   logic [OUT_W-1:0] lane_data;

   vlx_decode #(.SEL_W(SEL_W)) u_dec (
      .sel_i  (in_sel),
      .wide_i (in_q),
      .dec_o  (dec)
   );

   vlx_lane_mux #(.VEC_W(VEC_W), .SEL_W(SEL_W), .OUT_W(OUT_W)) u_mux (
      .vec_i  (in_vec),
      .sel_i  (in_sel),
      .esz_i  (dec.esz),
      .wide_i (in_q),
      .data_o (lane_data)
   );

   logic do_write;
   assign do_write = in_valid && !dec.undef;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         out_valid <= 1'b0;
         out_wr_en <= 1'b0;
         out_rd    <= '0;
         out_data  <= '0;
         out_undef <= 1'b0;
         out_alias <= 1'b0;
      end else begin
         out_valid <= in_valid;
         out_wr_en <= do_write;
         out_rd    <= in_valid ? in_rd : '0;
         out_data  <= do_write ? lane_data : '0;
         out_undef <= in_valid && dec.undef;
         out_alias <= in_valid && dec.alias_ok;
      end
   end

   // R1: reserved size bits give an undefined result
   a_r1_reserved_undef: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid && (in_sel[3:0] == 4'b0000) |=> out_undef && !out_wr_en);

   // R3: a doubleword lane with a 32-bit result is illegal
   a_r3_narrow_dbl: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid && !in_q && (in_sel[3:0] == 4'b1000) |=> out_undef);

   // R3: a sub-doubleword lane with a 64-bit result is illegal
   a_r3_wide_small: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid && in_q && (in_sel[2:0] != 3'b000) |=> out_undef);

   // R6: narrow results keep their upper half clear
   a_r6_narrow_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid && !in_q |=> (out_data[OUT_W-1:NARROW_W] == '0));

   // R7: an undefined move neither writes nor carries data
   a_r7_undef_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      out_undef |-> !out_wr_en && (out_data == '0));

   // R8: the alias flag only accompanies a legal write
   a_r8_alias_legal: assert property (@(posedge clk) disable iff (!rst_n)
      out_alias |-> out_wr_en && !out_undef);

   // R9: one-cycle latency and destination carried along
   a_r9_latency: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid |=> out_valid && (out_rd == $past(in_rd)));

   // R9: idle cycles raise nothing
   a_r9_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      !out_valid |-> !out_wr_en && !out_undef && !out_alias && (out_data == '0));

endmodule

// File: tb/vlane_extract_tb.sv
module vlane_extract_tb;

   logic         clk;
   logic         rst_n;
   logic         in_valid;
   logic [4:0]   in_sel;
   logic         in_q;
   logic [4:0]   in_rd;
   logic [127:0] in_vec;
   logic         out_valid;
   logic         out_wr_en;
   logic [4:0]   out_rd;
   logic [63:0]  out_data;
   logic         out_undef;
   logic         out_alias;

   int n_chk  = 0;
   int n_fail = 0;
   bit done   = 0;

   vlane_extract u_dut (
      .clk       (clk),
      .rst_n     (rst_n),
      .in_valid  (in_valid),
      .in_sel    (in_sel),
      .in_q      (in_q),
      .in_rd     (in_rd),
      .in_vec    (in_vec),
      .out_valid (out_valid),
      .out_wr_en (out_wr_en),
      .out_rd    (out_rd),
      .out_data  (out_data),
      .out_undef (out_undef),
      .out_alias (out_alias)
   );

   initial clk = 1'b0;
   always #4 clk = ~clk;

   task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   // expectation built from the requirement text
   task automatic model(input logic [4:0] sel, input logic q, input logic [127:0] v,
                        output logic undef, output logic al, output logic [63:0] data);
      int sz = -1;
      for (int i = 0; i < 4; i++) if (sel[i] && sz < 0) sz = i;
      if (sz < 0) undef = 1'b1;
      else undef = q ? (sz != 3) : (sz == 3);
      data = '0;
      al   = 1'b0;
      if (!undef) begin
         int ew  = 8 << sz;
         int idx = int'(sel) >> (sz + 1);
         logic [127:0] sh = v >> (idx * ew);
         data = (ew == 64) ? sh[63:0] : (sh[63:0] & ((64'd1 << ew) - 64'd1));
         al   = (sel[2:0] == 3'b100) || (sel[3:0] == 4'b1000);
      end
   endtask

   task automatic drive(input logic [4:0] sel, input logic q, input logic [4:0] rd);
      in_valid = 1'b1;
      in_sel   = sel;
      in_q     = q;
      in_rd    = rd;
   endtask

   task automatic check_out(input string req, input logic [4:0] sel, input logic q,
                            input logic [4:0] rd);
      logic u, a;
      logic [63:0] d;
      model(sel, q, in_vec, u, a, d);
      chk({req, " valid"}, 64'(out_valid), 64'd1);
      chk({req, " undef"}, 64'(out_undef), 64'(u));
      chk({req, " wr_en"}, 64'(out_wr_en), 64'(!u));
      chk({req, " data"},  out_data, d);
      chk({req, " alias R8"}, 64'(out_alias), 64'(a));
      chk({req, " rd R9"}, 64'(out_rd), 64'(rd));
   endtask

   task automatic one_move(input string req, input logic [4:0] sel, input logic q,
                           input logic [4:0] rd);
      @(negedge clk);
      drive(sel, q, rd);
      @(negedge clk);
      in_valid = 1'b0;
      check_out(req, sel, q, rd);
   endtask

   task automatic t_reset;
      chk("R10 valid", 64'(out_valid), 64'd0);
      chk("R10 wr_en", 64'(out_wr_en), 64'd0);
      chk("R10 data",  out_data, 64'd0);
      chk("R10 flags", {61'd0, out_undef, out_alias, out_rd != 0}, 64'd0);
   endtask

   task automatic t_reserved;
      for (int q = 0; q < 2; q++) begin
         one_move("R1 reserved 00000", 5'b00000, q[0], 5'd3);
         one_move("R1 reserved 10000", 5'b10000, q[0], 5'd4);
         chk("R7 reserved data zero", out_data, 64'd0);
      end
   endtask

   task automatic t_bytes;
      for (int i = 0; i < 16; i++) begin
         one_move("R2 R4 R5 byte lane", {i[3:0], 1'b1}, 1'b0, 5'(i));
         chk("R6 byte zero-ext", out_data, 64'(8'hA0 | 8'(i)));
      end
   endtask

   task automatic t_halves;
      for (int i = 0; i < 8; i++) begin
         one_move("R2 R4 R5 half lane", {i[2:0], 2'b10}, 1'b0, 5'(i + 1));
         chk("R6 half zero-ext", out_data,
             64'({8'hA0 | 8'(2*i+1), 8'hA0 | 8'(2*i)}));
      end
   endtask

   task automatic t_words;
      for (int i = 0; i < 4; i++)
         one_move("R2 R4 R5 word lane", {i[1:0], 3'b100}, 1'b0, 5'(i + 9));
      one_move("R5 dbl lane 0", 5'b01000, 1'b1, 5'd30);
      chk("R5 dbl lane 0 low half", out_data, 64'hA7A6A5A4A3A2A1A0);
      one_move("R5 dbl lane 1", 5'b11000, 1'b1, 5'd31);
      chk("R5 dbl lane 1 high half", out_data, 64'hAFAEADACABAAA9A8);
   endtask

   task automatic t_all_codes;
      for (int q = 0; q < 2; q++)
         for (int s = 0; s < 32; s++)
            one_move("R3 R7 R8 full sweep", 5'(s), q[0], 5'(s));
      one_move("R3 word with wide result", 5'b00100, 1'b1, 5'd2);
      chk("R3 wide word undef", 64'(out_undef), 64'd1);
      one_move("R3 dbl with narrow result", 5'b11000, 1'b0, 5'd2);
      chk("R3 narrow dbl undef", 64'(out_undef), 64'd1);
   endtask

   task automatic t_ones;
      in_vec = '1;
      one_move("R6 ones narrow word", 5'b10100, 1'b0, 5'd7);
      chk("R6 upper half clear", out_data, 64'h00000000FFFFFFFF);
      one_move("R6 ones byte", 5'b11111, 1'b0, 5'd7);
      chk("R6 byte extend", out_data, 64'h00000000000000FF);
      one_move("R6 ones dbl", 5'b11000, 1'b1, 5'd7);
      chk("R6 full dbl", out_data, 64'hFFFFFFFFFFFFFFFF);
   endtask

   task automatic t_pipeline;
      in_vec = 128'h0123456789ABCDEF_FEDCBA9876543210;
      @(negedge clk);
      drive(5'b00110, 1'b0, 5'd12);
      @(negedge clk);
      check_out("R9 back-to-back first", 5'b00110, 1'b0, 5'd12);
      drive(5'b11000, 1'b1, 5'd13);
      @(negedge clk);
      check_out("R9 back-to-back second", 5'b11000, 1'b1, 5'd13);
      in_valid = 1'b0;
      in_sel   = 5'b00100;
      in_q     = 1'b0;
      in_rd    = 5'd9;
      @(negedge clk);
      chk("R9 idle valid", 64'(out_valid), 64'd0);
      chk("R9 idle wr_en", 64'(out_wr_en), 64'd0);
      chk("R9 idle data",  out_data, 64'd0);
      chk("R9 idle flags", {62'd0, out_undef, out_alias}, 64'd0);
   endtask

   initial begin
      rst_n    = 1'b0;
      in_valid = 1'b0;
      in_sel   = '0;
      in_q     = 1'b0;
      in_rd    = '0;
      for (int k = 0; k < 16; k++) in_vec[k*8 +: 8] = 8'hA0 | 8'(k);
      repeat (3) @(negedge clk);
      t_reset();
      rst_n = 1'b1;
      t_reserved();
      t_bytes();
      t_halves();
      t_words();
      t_all_codes();
      t_ones();
      t_pipeline();
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         n_chk++;
         n_fail++;
         $display("FAIL watchdog: actual running expected finished");
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end

endmodule